// File: doc/BRIEF.md
# UART Auto-Baud Calibrator

This block measures the bit time of an incoming asynchronous sync character of value 0x55 and leaves the measured baud divisor in a counter that software reads as the divisor register pair. Software requests a calibration with a start strobe. The block then sets its busy bit, which also holds the receiver state machine idle. It waits for the start bit's falling edge, and after that it times the span from the first rising edge to the fifth rising edge of the character. That span is eight bit periods.

The counter is fed by a prescaler that runs at one eighth of the normal baud base rate. The final count is therefore the average single-bit divisor, plus one because the count starts at 1. Two mode bits choose the prescale ratio. The counter always uses its full width, whatever the wide-divisor mode bit says. At completion the busy bit clears itself and a done flag rises. A read strobe of the receive data register clears that flag. If the count would pass all ones, it stays at all ones and a sticky overflow bit is set.

Top module: `uart_baud_calib`

## Requirements
- R1: After reset, calBusy, rxHoldIdle, rxDoneFlag and ovfFlag are 0 and divisor is 0.
- R2: A calStart pulse while idle sets calBusy one cycle later and clears divisor and ovfFlag. rxHoldIdle equals calBusy at all times.
- R3: The measured value is 1 + floor((8*B - 1)/P). Here B is the bit time in clock cycles of a 0x55 character (LSB first, start bit 0, stop bit 1) and P is the selected prescale ratio. Timing runs from the first rising edge after the start bit to the fifth rising edge.
- R4: The prescale ratio P is selected by {modeWide, modeFast}: 2'b00 gives PRE_SLOW, 2'b01 and 2'b10 give PRE_MID, and 2'b11 gives PRE_FAST.
- R5: The counter is CNT_W bits wide in every mode. With modeWide=0 a result above 255 is still reported in full.
- R6: calBusy falls and rxDoneFlag rises in the same cycle. divisor then stays stable until the next accepted calStart.
- R7: rdStrobe clears rxDoneFlag on the next cycle. If completion and rdStrobe fall in the same cycle, the flag is set.
- R8: If the count would pass all ones, divisor stays at all ones and ovfFlag is set. ovfFlag stays set until the next accepted calStart.
- R9: A calStart pulse while calBusy is 1 has no effect on the measurement or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxIn | input | 1 | Raw asynchronous receive line |
| calStart | input | 1 | Software strobe that requests a calibration |
| modeWide | input | 1 | Wide-divisor mode bit (part of prescale select) |
| modeFast | input | 1 | High-speed mode bit (part of prescale select) |
| rdStrobe | input | 1 | Read strobe of the receive data register |
| calBusy | output | 1 | Calibration enable bit, clears itself at completion |
| rxHoldIdle | output | 1 | Holds the receiver state machine idle |
| rxDoneFlag | output | 1 | Receive interrupt flag set at completion |
| ovfFlag | output | 1 | Sticky counter saturation flag |
| divisor | output | CNT_W | Measured divisor (high:low register pair) |

## Verification
The done flag's set from completion and its clear from rdStrobe can land on the same clock edge. To provoke this, the bench raises rdStrobe exactly in the cycle in which the fifth rising edge is seen: it is asserted two clock edges after the stop-bit edge is driven, which is where the two-flop synchronizer and edge compare put the detection. The collision is judged correct if the flag reads 1 after that edge, and a later isolated rdStrobe is then shown to clear it.

// File: rtl/baud_calib_pkg.sv
package baud_calib_pkg;
  // Strobes from the control unit to the datapath.
  typedef struct packed {
    logic clrCount;  // clear counter, prescaler and overflow
    logic loadOne;   // counter restarts at 1 on the first timed edge
    logic runCount;  // prescaler and counter advance
  } dp_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAIT1,
    ST_COUNT
  } cal_state_t;
endpackage

// File: rtl/baud_calib_dp.sv
module baud_calib_dp
  import baud_calib_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_SLOW = 512,
  parameter int PRE_MID  = 128,
  parameter int PRE_FAST = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             modeWide,
  input  logic             modeFast,
  input  dp_ctl_t          ctl,
  output logic             rxRise,
  output logic             rxFall,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam int PRE_W = $clog2(PRE_SLOW + 1);
  localparam logic [PRE_W-1:0] LAST_SLOW = PRE_W'(PRE_SLOW - 1);
  localparam logic [PRE_W-1:0] LAST_MID  = PRE_W'(PRE_MID - 1);
  localparam logic [PRE_W-1:0] LAST_FAST = PRE_W'(PRE_FAST - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;

  logic rxMeta, rxSync, rxPrev;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;

  // Two-flop synchronizer plus a history flop for edge detection.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
      rxPrev <= rxSync;
    end
  end

  assign rxRise = rxSync & ~rxPrev;
  assign rxFall = ~rxSync & rxPrev;

  always_comb begin
    unique case ({modeWide, modeFast})
      2'b00:   preLast = LAST_SLOW;
      2'b11:   preLast = LAST_FAST;
      default: preLast = LAST_MID;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (ctl.clrCount) begin
      preCnt <= '0;
      count  <= '0;
      ovf    <= 1'b0;
    end else if (ctl.loadOne) begin
      preCnt <= '0;
      count  <= CNT_W'(1);
    end else if (ctl.runCount) begin
      if (preCnt == preLast) begin
        preCnt <= '0;
        if (count == CNT_MAX) ovf <= 1'b1;
        else                  count <= count + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/baud_calib_ctrl.sv
module baud_calib_ctrl
  import baud_calib_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    calStart,
  input  logic    rdStrobe,
  input  logic    rxRise,
  input  logic    rxFall,
  output dp_ctl_t ctl,
  output logic    busy,
  output logic    doneFlag
);
  localparam int EDGE_TOTAL = 5;
  localparam int EDGE_W = $clog2(EDGE_TOTAL + 1);
  localparam logic [EDGE_W-1:0] EDGE_LAST = EDGE_W'(EDGE_TOTAL - 1);

  cal_state_t state, stateNext;
  logic [EDGE_W-1:0] edgeCnt, edgeCntNext;
  logic doneStb;

  always_comb begin
    stateNext   = state;
    edgeCntNext = edgeCnt;
    ctl         = '0;
    doneStb     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (calStart) begin
          ctl.clrCount = 1'b1;
          stateNext    = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (rxFall) stateNext = ST_WAIT1;
      end
      ST_WAIT1: begin
        if (rxRise) begin
          ctl.loadOne = 1'b1;
          edgeCntNext = EDGE_W'(1);
          stateNext   = ST_COUNT;
        end
      end
      ST_COUNT: begin
        if (rxRise && edgeCnt == EDGE_LAST) begin
          doneStb   = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.runCount = 1'b1;
          if (rxRise) edgeCntNext = edgeCnt + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      edgeCnt  <= '0;
      doneFlag <= 1'b0;
    end else begin
      state   <= stateNext;
      edgeCnt <= edgeCntNext;
      if (doneStb)       doneFlag <= 1'b1;
      else if (rdStrobe) doneFlag <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/uart_baud_calib.sv
module uart_baud_calib
  import baud_calib_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRE_SLOW = 512,
  parameter int PRE_MID  = 128,
  parameter int PRE_FAST = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             calStart,
  input  logic             modeWide,
  input  logic             modeFast,
  input  logic             rdStrobe,
  output logic             calBusy,
  output logic             rxHoldIdle,
  output logic             rxDoneFlag,
  output logic             ovfFlag,
  output logic [CNT_W-1:0] divisor
);
  dp_ctl_t ctl;
  logic rxRise, rxFall;

  baud_calib_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .calStart (calStart),
    .rdStrobe (rdStrobe),
    .rxRise   (rxRise),
    .rxFall   (rxFall),
    .ctl      (ctl),
    .busy     (calBusy),
    .doneFlag (rxDoneFlag)
  );

  baud_calib_dp #(
    .CNT_W    (CNT_W),
    .PRE_SLOW (PRE_SLOW),
    .PRE_MID  (PRE_MID),
    .PRE_FAST (PRE_FAST)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .modeWide (modeWide),
    .modeFast (modeFast),
    .ctl      (ctl),
    .rxRise   (rxRise),
    .rxFall   (rxFall),
    .count    (divisor),
    .ovf      (ovfFlag)
  );

  assign rxHoldIdle = calBusy;
endmodule

// File: rtl/baud_calib_chk.sv
module baud_calib_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             calStart,
  input logic             rdStrobe,
  input logic             calBusy,
  input logic             rxHoldIdle,
  input logic             rxDoneFlag,
  input logic             ovfFlag,
  input logic [CNT_W-1:0] divisor
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (calStart && !calBusy) |=> (calBusy && rxHoldIdle && divisor == '0 && !ovfFlag));

  // R6
  done_together_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(calBusy) |-> rxDoneFlag);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!calBusy && !calStart) |=> $stable(divisor));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && !calBusy) |=> !rxDoneFlag);

  // R8
  sat_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> (divisor == ALL_ONES));

  // R8
  sat_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(calStart && !calBusy)) |=> (ovfFlag && divisor == ALL_ONES));
endmodule

bind uart_baud_calib baud_calib_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .calStart   (calStart),
  .rdStrobe   (rdStrobe),
  .calBusy    (calBusy),
  .rxHoldIdle (rxHoldIdle),
  .rxDoneFlag (rxDoneFlag),
  .ovfFlag    (ovfFlag),
  .divisor    (divisor)
);

// File: tb/tb_uart_baud_calib.sv
module tb_uart_baud_calib;
  localparam int CNT_W    = 12;
  localparam int PRE_SLOW = 16;
  localparam int PRE_MID  = 8;
  localparam int PRE_FAST = 4;
  localparam int CMAX     = (1 << CNT_W) - 1;
  localparam int NVEC     = 6;

  // {modeWide, modeFast, bit time in clocks}
  typedef struct packed { logic w; logic f; int unsigned bitClks; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 40},    // R4 slow
    '{1'b0, 1'b1, 40},    // R4 mid
    '{1'b1, 1'b0, 33},    // R4 mid
    '{1'b1, 1'b1, 37},    // R4 fast
    '{1'b0, 1'b0, 700},   // R5 result above 255 with modeWide=0
    '{1'b1, 1'b1, 2100}   // R8 saturation
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxIn = 1'b1;
  logic calStart = 1'b0;
  logic modeWide = 1'b0;
  logic modeFast = 1'b0;
  logic rdStrobe = 1'b0;
  logic calBusy, rxHoldIdle, rxDoneFlag, ovfFlag;
  logic [CNT_W-1:0] divisor;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uart_baud_calib #(
    .CNT_W(CNT_W), .PRE_SLOW(PRE_SLOW), .PRE_MID(PRE_MID), .PRE_FAST(PRE_FAST)
  ) dut (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .calStart(calStart),
    .modeWide(modeWide), .modeFast(modeFast), .rdStrobe(rdStrobe),
    .calBusy(calBusy), .rxHoldIdle(rxHoldIdle), .rxDoneFlag(rxDoneFlag),
    .ovfFlag(ovfFlag), .divisor(divisor)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int preOf(input logic w, input logic f);
    if (!w && !f) return PRE_SLOW;
    if (w && f)   return PRE_FAST;
    return PRE_MID;
  endfunction

  function automatic int expOf(input logic w, input logic f, input int b);
    int raw;
    raw = 1 + (8 * b - 1) / preOf(w, f);
    return (raw > CMAX) ? CMAX : raw;
  endfunction

  // Send 0x55, LSB first. midStart: pulse calStart during bit 3.
  // coin: raise rdStrobe in the cycle the fifth rising edge is detected.
  task automatic sendSync(input int b, input bit midStart, input bit coin);
    logic [9:0] frame;
    frame = {1'b1, 8'h55, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < b; c++) begin
        if (c == 0) rxIn = frame[i];
        calStart = (midStart && i == 4 && c == 0);
        rdStrobe = (coin && i == 9 && c == 2);
        @(negedge clk);
      end
    end
    calStart = 1'b0;
    rdStrobe = 1'b0;
  endtask

  task automatic startCal(input logic w, input logic f);
    modeWide = w;
    modeFast = f;
    calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0;
    check("R2", "busy after start", calBusy, 1);
    check("R2", "holdIdle after start", rxHoldIdle, 1);
    check("R2", "divisor cleared at start", divisor, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic readFlag();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    check("R7", "flag after read", rxDoneFlag, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "busy in reset", calBusy, 0);
    check("R1", "flag in reset", rxDoneFlag, 0);
    check("R1", "ovf in reset", ovfFlag, 0);
    check("R1", "divisor in reset", divisor, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "holdIdle after reset", rxHoldIdle, 0);

    for (int v = 0; v < NVEC; v++) begin
      int e;
      e = expOf(VECS[v].w, VECS[v].f, int'(VECS[v].bitClks));
      startCal(VECS[v].w, VECS[v].f);
      sendSync(int'(VECS[v].bitClks), 1'b0, 1'b0);
      check("R3", "divisor", divisor, e);
      check("R6", "busy cleared", calBusy, 0);
      check("R6", "flag set", rxDoneFlag, 1);
      check("R8", "ovf", ovfFlag, (1 + (8 * int'(VECS[v].bitClks) - 1) / preOf(VECS[v].w, VECS[v].f)) > CMAX);
      if (v == 4) check("R5", "full width in narrow mode", divisor > 255, 1);
      repeat (20) @(negedge clk);
      check("R6", "divisor held", divisor, e);
      if (v == 5) check("R8", "ovf sticky", ovfFlag, 1);
      readFlag();
    end

    // R8 ovf cleared by next accepted start
    startCal(1'b1, 1'b1);
    check("R8", "ovf cleared by start", ovfFlag, 0);
    sendSync(37, 1'b1, 1'b0);  // R9 start pulse during measurement
    check("R9", "divisor with mid start", divisor, expOf(1'b1, 1'b1, 37));
    check("R9", "flag with mid start", rxDoneFlag, 1);
    readFlag();

    // R7 completion and read in the same cycle
    startCal(1'b0, 1'b1);
    sendSync(40, 1'b0, 1'b1);
    check("R7", "flag wins over read", rxDoneFlag, 1);
    check("R3", "divisor in collision run", divisor, expOf(1'b0, 1'b1, 40));
    readFlag();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule